// File: doc/BRIEF.md
# Serial Character-Time and Receive-Timeout Timer

This block measures time in whole serial characters for a byte-oriented asynchronous receiver. It works out how many bit periods one character frame holds from the current line-control setting. It divides a base-clock tick stream by sixteen times the programmed divisor to get bit periods. It then counts bit periods into a one-cycle pulse at each character boundary.

On top of that time base it runs the receive-idle timeout. While the receive queue holds data and nothing happens on the receive side, the block counts character times. After the fourth one it raises a timeout flag. A new received byte or a read from the queue restarts the character timer and the idle count. An empty queue clears the flag.

A zero divisor parks every counter, so no character ticks and no timeout are produced. The actual shifting of bits onto or off the line happens elsewhere. A typical setting is a line-control value of 0x03 with a divisor of 12: eight data bits, no parity, one stop bit, a 10-bit frame and 1920 base ticks per character.

Top module: `uart_char_timer`

## Requirements
- R1: `frame_bits` equals 1 start bit + data bits + parity bit + stop bits, where the data-bit count is `line_ctrl[1:0]` + 5 (so 5 to 8 data bits).
- R2: `line_ctrl[3]` = 1 adds one parity bit to `frame_bits`. `line_ctrl[4]` (even when 1, odd when 0) does not change `frame_bits`. Bits 7:5 have no effect.
- R3: `line_ctrl[2]` = 1 gives two stop bits, and 0 gives one.
- R4: With a non-zero divisor D, one bit time is 16·D accepted `base_tick` cycles. `char_tick` is a one-cycle pulse once every `frame_bits` bit times, so with `base_tick` high every cycle the pulse period is 16·D·`frame_bits` clocks, and with `base_tick` high every other cycle it is twice that.
- R5: `rx_event` high at a clock edge restarts the bit and character counters. The first `char_tick` after it is high in the clock cycle that follows the (16·D·`frame_bits` − 1)-th edge after that edge.
- R6: With `fifo_nonempty` held at 1 and no `rx_event`, `rx_timeout` rises at the edge that ends the fourth character time after the last `rx_event` (edge number 4·16·D·`frame_bits` after it). The flag stays low before that edge.
- R7: `rx_event` clears `rx_timeout` and the idle count at the next edge. This holds even in the cycle in which the fourth character time would have ended, and the flag then rises four full character times later.
- R8: `fifo_nonempty` = 0 clears `rx_timeout` and the idle count at the next edge.
- R9: While the divisor is 0, no `char_tick` occurs and `rx_timeout` does not rise.
- R10: While `rst_n` is low, and right after it, `char_tick` and `rx_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_ctrl | input | 8 | Line-control byte (word length, stop bits, parity enable, parity sense) |
| divisor | input | 16 | Baud divisor; 0 halts timing |
| base_tick | input | 1 | Base-clock enable; one accepted tick per high cycle |
| rx_event | input | 1 | Receive activity or queue read; restarts timing |
| fifo_nonempty | input | 1 | Receive queue holds at least one entry |
| frame_bits | output | 4 | Bits per character frame |
| char_tick | output | 1 | One-cycle pulse at each character-time boundary |
| rx_timeout | output | 1 | Receive idle timeout flag |

## Verification
Two things can land in the same cycle: the end of the fourth idle character time, and a restart from receive activity. The bench starts a count with a restart pulse. It then counts clocks until one cycle before the edge on which the flag would rise, and raises `rx_event` so that the restart and the expiring count meet at one edge. That case passes only if the flag stays low at that edge and then rises exactly four character times later, measured from the new restart. The same bench also drops the queue-not-empty flag partway through a count and checks that the original deadline passes without a timeout.

// File: rtl/uct_pkg.sv
`timescale 1ns/1ps
package uct_pkg;

    localparam int unsigned LC_W        = 8;
    localparam int unsigned FRAME_W     = 4;
    localparam int unsigned DATA_BASE   = 5;

    // field positions inside the line-control byte
    localparam int unsigned LC_WLEN_LSB = 0;
    localparam int unsigned LC_STOP2    = 2;
    localparam int unsigned LC_PAR_EN   = 3;
    localparam int unsigned LC_PAR_EVEN = 4;

    typedef logic [FRAME_W-1:0] frame_len_t;

    function automatic frame_len_t calc_frame(input logic [LC_W-1:0] lc);
        frame_len_t n;
        n = frame_len_t'(1)                                       // start
          + frame_len_t'(DATA_BASE)
          + frame_len_t'(lc[LC_WLEN_LSB +: 2])                    // data
          + frame_len_t'(lc[LC_PAR_EN])                           // parity
          + (lc[LC_STOP2] ? frame_len_t'(2) : frame_len_t'(1));   // stop
        return n;
    endfunction

endpackage

// File: rtl/uct_frame_len.sv
`timescale 1ns/1ps
module uct_frame_len
    import uct_pkg::*;
(
    input  logic [LC_W-1:0] line_ctrl,
    output frame_len_t      frame_bits
);
    // parity sense and the upper bits never change the length
    logic unused_lc;
    assign unused_lc = ^{line_ctrl[LC_W-1:LC_PAR_EVEN+1], line_ctrl[LC_PAR_EVEN]};

    always_comb begin
        frame_bits = calc_frame(line_ctrl);
    end

endmodule

// File: rtl/uct_bit_timer.sv
`timescale 1ns/1ps
module uct_bit_timer #(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_tick
);
    localparam int unsigned SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [DIV_W-1:0] div;
    } bt_state_t;

    bt_state_t st_d, st_q;
    logic      tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = 1'b0;
        if (restart || divisor == '0) begin
            st_d = '0;
        end else if (base_tick) begin
            if (st_q.sub >= SUB_LAST) begin
                st_d.sub = '0;
                if (st_q.div >= divisor - DIV_W'(1)) begin
                    st_d.div = '0;
                    tick_d   = 1'b1;
                end else begin
                    st_d.div = st_q.div + DIV_W'(1);
                end
            end else begin
                st_d.sub = st_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick = tick_d;

    // R9
    zero_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> (st_q.sub == '0 && st_q.div == '0));

    // R4
    bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (st_q.sub == '0 && st_q.div == '0));

endmodule

// File: rtl/uct_char_counter.sv
`timescale 1ns/1ps
module uct_char_counter
    import uct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       bit_tick,
    input  frame_len_t frame_bits,
    output logic       char_tick
);
    typedef struct packed {
        frame_len_t cnt;
    } cc_state_t;

    cc_state_t st_d, st_q;
    logic      tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = 1'b0;
        if (restart || !run) begin
            st_d.cnt = '0;
        end else if (bit_tick) begin
            if (st_q.cnt >= frame_bits - frame_len_t'(1)) begin
                st_d.cnt = '0;
                tick_d   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + frame_len_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign char_tick = tick_d;

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

    // R4
    char_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_tick |-> bit_tick);

endmodule

// File: rtl/uct_timeout.sv
`timescale 1ns/1ps
module uct_timeout #(
    parameter int unsigned TIMEOUT_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rx_event,
    input  logic fifo_nonempty,
    input  logic char_tick,
    output logic rx_timeout
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CHARS + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CHARS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } to_state_t;

    to_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fifo_nonempty || rx_event) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (!run) begin
            st_d.cnt = '0;
        end else if (char_tick && st_q.cnt < CNT_LIMIT) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt + CNT_W'(1) == CNT_LIMIT) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_timeout = st_q.flag;

    // R8
    empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !rx_timeout);

    // R7
    event_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_timeout);

    // R6
    rise_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_timeout) |-> $past(char_tick));

endmodule

// File: rtl/uart_char_timer.sv
`timescale 1ns/1ps
module uart_char_timer
    import uct_pkg::*;
#(
    parameter int unsigned DIV_W         = 16,
    parameter int unsigned OVERSAMPLE    = 16,
    parameter int unsigned TIMEOUT_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LC_W-1:0]    line_ctrl,
    input  logic [DIV_W-1:0]   divisor,
    input  logic               base_tick,
    input  logic               rx_event,
    input  logic               fifo_nonempty,
    output logic [FRAME_W-1:0] frame_bits,
    output logic               char_tick,
    output logic               rx_timeout
);
    logic run;
    logic bit_tick;

    assign run = (divisor != '0);

    uct_frame_len u_frame (
        .line_ctrl  (line_ctrl),
        .frame_bits (frame_bits)
    );

    uct_bit_timer #(
        .DIV_W      (DIV_W),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .restart   (rx_event),
        .divisor   (divisor),
        .bit_tick  (bit_tick)
    );

    uct_char_counter u_char (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (rx_event),
        .run        (run),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .char_tick  (char_tick)
    );

    uct_timeout #(
        .TIMEOUT_CHARS (TIMEOUT_CHARS)
    ) u_tmo (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .rx_event      (rx_event),
        .fifo_nonempty (fifo_nonempty),
        .char_tick     (char_tick),
        .rx_timeout    (rx_timeout)
    );

    // R9
    halted_no_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !char_tick);

endmodule

// File: tb/uart_char_timer_tb.sv
`timescale 1ns/1ps
module uart_char_timer_tb;
    localparam int OS    = 16;
    localparam int LIMIT = 40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lcr = 8'h03;
    logic [15:0] dv = 16'd1;
    logic        btick = 1'b1;
    logic        rxev = 1'b0;
    logic        nonempty = 1'b0;
    logic        gap = 1'b0;
    logic [3:0]  fbits;
    logic        ctick;
    logic        tmo;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_char_timer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_ctrl     (lcr),
        .divisor       (dv),
        .base_tick     (btick),
        .rx_event      (rxev),
        .fifo_nonempty (nonempty),
        .frame_bits    (fbits),
        .char_tick     (ctick),
        .rx_timeout    (tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int frame_of(input logic [7:0] l);
        return 1 + 5 + int'(l[1:0]) + int'(l[3]) + (l[2] ? 2 : 1);
    endfunction

    task automatic step();
        @(negedge clk);
        if (gap) btick = ~btick;
    endtask

    // leaves time at the first negedge after the capturing edge (k = 1)
    task automatic pulse_event();
        step();
        rxev = 1'b1;
        @(posedge clk);
        step();
        rxev = 1'b0;
    endtask

    task automatic wait_tick(output int k);
        k = 1;
        while (!ctick && k < LIMIT) begin step(); k++; end
    endtask

    task automatic wait_tmo(output int k);
        k = 1;
        while (!tmo && k < LIMIT) begin step(); k++; end
    endtask

    task automatic measure_period(output int k);
        step();
        k = 1;
        while (!ctick && k < LIMIT) begin step(); k++; end
    endtask

    task automatic char_case(input logic [7:0] l, input int d);
        int k;
        int p;
        lcr = l; dv = 16'(d); nonempty = 1'b0;
        p = OS * d * frame_of(l);
        pulse_event();
        wait_tick(k);
        chk($sformatf("R5 first tick lcr=%02h div=%0d", l, d), k, p);
        measure_period(k);
        chk($sformatf("R4 period lcr=%02h div=%0d", l, d), k, p);
    endtask

    task automatic tmo_case(input logic [7:0] l, input int d);
        int k;
        int p;
        lcr = l; dv = 16'(d);
        p = OS * d * frame_of(l);
        nonempty = 1'b1;
        pulse_event();
        wait_tmo(k);
        chk($sformatf("R6 timeout edge lcr=%02h div=%0d", l, d), k, 4 * p + 1);
        step(); nonempty = 1'b0;
        step();
        chk("R8 empty clears flag", int'(tmo), 0);
    endtask

    initial begin
        int k;
        int p;
        int nt;
        int nf;

        // R10: reset
        nonempty = 1'b1;
        repeat (3) step();
        chk("R10 char_tick in reset", int'(ctick), 0);
        chk("R10 timeout in reset", int'(tmo), 0);
        rst_n = 1'b1;
        step();
        chk("R10 char_tick after reset", int'(ctick), 0);
        chk("R10 timeout after reset", int'(tmo), 0);
        nonempty = 1'b0;

        // R1 R2 R3: full line-control sweep
        for (int v = 0; v < 256; v++) begin
            step();
            lcr = 8'(v);
            #1;
            chk($sformatf("R1 frame lcr=%02h", v), int'(fbits), frame_of(8'(v)));
        end
        for (int v = 0; v < 32; v++) begin
            int a;
            step(); lcr = 8'(v) & 8'hEF; #1; a = int'(fbits);
            step(); lcr = 8'(v) | 8'h10; #1;
            chk($sformatf("R2 parity sense lcr=%02h", v), int'(fbits), a);
            step(); lcr = 8'(v) & 8'hF7; #1; a = int'(fbits);
            step(); lcr = 8'(v) | 8'h08; #1;
            chk($sformatf("R2 parity enable lcr=%02h", v), int'(fbits), a + 1);
            step(); lcr = 8'(v) & 8'hFB; #1; a = int'(fbits);
            step(); lcr = 8'(v) | 8'h04; #1;
            chk($sformatf("R3 two stop lcr=%02h", v), int'(fbits), a + 1);
        end

        // R4 R5: character periods over a small grid
        for (int d = 1; d <= 3; d++) begin
            char_case(8'h00, d);
            char_case(8'h03, d);
            char_case(8'h0F, d);
            char_case(8'h1C, d);
        end

        // R4: base tick every other cycle doubles the period
        lcr = 8'h03; dv = 16'd2; nonempty = 1'b0;
        gap = 1'b1;
        pulse_event();
        wait_tick(k);
        measure_period(k);
        chk("R4 gapped period", k, 2 * OS * 2 * frame_of(8'h03));
        gap = 1'b0;
        step(); btick = 1'b1;

        // R6 R8
        tmo_case(8'h03, 1);
        tmo_case(8'h0B, 2);
        tmo_case(8'h04, 1);

        // R7: restart on the very edge where the fourth character ends
        lcr = 8'h00; dv = 16'd1; nonempty = 1'b1;
        p = OS * frame_of(8'h00);
        pulse_event();
        k = 1;
        while (k < 4 * p) begin step(); k++; end
        chk("R6 flag low before deadline", int'(tmo), 0);
        rxev = 1'b1;
        @(posedge clk);
        step();
        rxev = 1'b0;
        chk("R7 restart wins at deadline", int'(tmo), 0);
        wait_tmo(k);
        chk("R7 rise after restart", k, 4 * p + 1);
        step(); rxev = 1'b1;
        @(posedge clk);
        step(); rxev = 1'b0;
        chk("R7 event clears raised flag", int'(tmo), 0);

        // R8: brief empty during the count postpones the timeout
        pulse_event();
        k = 1;
        while (k < 2 * p) begin step(); k++; end
        nonempty = 1'b0;
        step(); k++;
        nonempty = 1'b1;
        while (k < 4 * p + 1) begin step(); k++; end
        chk("R8 empty resets idle count", int'(tmo), 0);
        step(); nonempty = 1'b0;
        step();

        // R9: zero divisor halts everything
        dv = 16'd0; lcr = 8'h00; nonempty = 1'b1;
        nt = 0; nf = 0;
        for (int i = 0; i < 3000; i++) begin
            step();
            if (ctick) nt++;
            if (tmo)   nf++;
        end
        chk("R9 no char ticks at divisor 0", nt, 0);
        chk("R9 no timeout at divisor 0", nf, 0);

        // R1 R6: common setting, 10-bit frame, divisor 12
        tmo_case(8'h03, 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule